// File: doc/BRIEF.md
# Pin Change Interrupt Controller

This block watches an 8-pin input port and turns selected signal transitions into a CPU interrupt. Every pin has two enable bits: one arms it for low-to-high transitions and one arms it for high-to-low transitions. Either bit, or both, may be set. A detected transition on an armed pin sets that pin's sticky flag. Software reads the flags and clears the ones it has serviced.

The pins are asynchronous to the clock, so each one passes through a synchronizer before transitions are detected. The OR of all flags forms a summary output. The interrupt output is that summary gated by a master enable input. While the core is in sleep, the same gated summary drives a wake request. A flag therefore always holds its value before the wake request reaches the core. When the master enable is low, flags still latch, so software can poll them.

Software reaches three registers through a small word-wide port with a combinational read. Hardware takes priority on the flags: a transition detected in the same cycle as a software clear leaves the flag set.

Top module: `pin_change_irq`

## Requirements
- R1: Register select `addr_i` picks the rising enables (0), the falling enables (1) or the flags (2), and select 3 reads as 0x00. Bit i of every register belongs to pin i. `rdata_o` follows `addr_i` combinationally, and a write with `wr_en_i` high takes effect at the next clock edge.
- R2: A pin's flag sets on a low-to-high transition when its rising enable is 1, and on a high-to-low transition when its falling enable is 1. With both enables set, either direction sets the flag. A pin value sampled at clock edge k shows in the flag after edge k+2.
- R3: When `master_en_i` is 0, flags still set on enabled transitions, but `irq_o` stays 0.
- R4: `irq_o` is high exactly when the summary is high and `master_en_i` is 1.
- R5: `summary_o` is the OR of all eight flags.
- R6: A write to the flag register clears each bit written as 0 and leaves each bit written as 1 unchanged. Software can never set a flag.
- R7: When a transition on an enabled pin is detected in the same cycle as a flag write that clears that pin's bit, the flag ends up set.
- R8: Changing an enable bit never sets a flag by itself. The pin level present across reset release is not taken as a transition.
- R9: `wake_o` is high exactly when `sleep_i`, `master_en_i` and the summary are all high.
- R10: Reset (`rst_ni` low) clears all enable bits and all flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pins_i | input | 8 | Asynchronous port pins |
| master_en_i | input | 1 | Master interrupt enable |
| sleep_i | input | 1 | Core is in low-power sleep |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register select |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for the selected register |
| summary_o | output | 1 | OR of all pin flags |
| irq_o | output | 1 | Interrupt request to the core |
| wake_o | output | 1 | Wake request out of sleep |

## Verification
Two things can land in the same clock edge: a hardware flag set caused by a detected transition, and a software write to the flag register that clears that same bit. The bench raises a pin so that its transition is detected exactly two edges after the pin is sampled, and it places the clearing write on that edge. A second flag is cleared in the same write. The read-back must show the contested bit still set and the other bit cleared. The behavioural model, compared on every clock, judges every other cycle by the same set-wins rule.

// File: rtl/pcirq_pkg.sv
package pcirq_pkg;
  typedef enum logic [1:0] {
    SEL_RISE = 2'd0,
    SEL_FALL = 2'd1,
    SEL_FLAG = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/pcirq_sync.sv
module pcirq_sync #(
  parameter int unsigned W      = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[s] <= '0;
        else         stg_q[s] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[s] <= '0;
        else         stg_q[s] <= stg_q[s-1];
      end
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/pcirq_edge.sv
module pcirq_edge #(
  parameter int unsigned W      = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] sync_i,
  input  logic [W-1:0] rise_en_i,
  input  logic [W-1:0] fall_en_i,
  output logic [W-1:0] set_o
);
  // detection held off until prev_q holds a real synchronized sample
  localparam int unsigned PRIME = STAGES + 1;
  localparam int unsigned CW    = $clog2(PRIME + 1);

  logic [W-1:0]  prev_q;
  logic [CW-1:0] prime_q;
  logic          primed;

  assign primed = (prime_q == CW'(PRIME));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q  <= '0;
      prime_q <= '0;
    end else begin
      prev_q <= sync_i;
      if (!primed) prime_q <= prime_q + 1'b1;
    end
  end

  for (genvar i = 0; i < W; i++) begin : g_pin
    logic up, down;
    assign up       = sync_i[i] & ~prev_q[i];
    assign down     = ~sync_i[i] & prev_q[i];
    assign set_o[i] = primed & ((up & rise_en_i[i]) | (down & fall_en_i[i]));
  end
endmodule

// File: rtl/pcirq_regs.sv
module pcirq_regs
  import pcirq_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_en_i,
  input  logic [1:0]   addr_i,
  input  logic [W-1:0] wdata_i,
  input  logic [W-1:0] set_i,
  output logic [W-1:0] rise_en_o,
  output logic [W-1:0] fall_en_o,
  output logic [W-1:0] flag_o,
  output logic [W-1:0] rdata_o
);
  reg_sel_e     sel;
  logic [W-1:0] rise_q, fall_q, flag_q, clr_mask;

  assign sel      = reg_sel_e'(addr_i);
  assign clr_mask = (wr_en_i && sel == SEL_FLAG) ? ~wdata_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rise_q <= '0;
      fall_q <= '0;
      flag_q <= '0;
    end else begin
      if (wr_en_i && sel == SEL_RISE) rise_q <= wdata_i;
      if (wr_en_i && sel == SEL_FALL) fall_q <= wdata_i;
      // hardware set wins over a same-cycle clear
      flag_q <= (flag_q & ~clr_mask) | set_i;
    end
  end

  always_comb begin
    unique case (sel)
      SEL_RISE: rdata_o = rise_q;
      SEL_FALL: rdata_o = fall_q;
      SEL_FLAG: rdata_o = flag_q;
      default:  rdata_o = '0;
    endcase
  end

  assign rise_en_o = rise_q;
  assign fall_en_o = fall_q;
  assign flag_o    = flag_q;
endmodule

// File: rtl/pin_change_irq.sv
module pin_change_irq #(
  parameter int unsigned W           = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] pins_i,
  input  logic         master_en_i,
  input  logic         sleep_i,
  input  logic         wr_en_i,
  input  logic [1:0]   addr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] rdata_o,
  output logic         summary_o,
  output logic         irq_o,
  output logic         wake_o
);
  logic [W-1:0] pins_sync, rise_en, fall_en, edge_set, flag_q;

  pcirq_sync #(.W(W), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pins_i),
    .q_o    (pins_sync)
  );

  pcirq_edge #(.W(W), .STAGES(SYNC_STAGES)) u_edge (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sync_i    (pins_sync),
    .rise_en_i (rise_en),
    .fall_en_i (fall_en),
    .set_o     (edge_set)
  );

  pcirq_regs #(.W(W)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .addr_i    (addr_i),
    .wdata_i   (wdata_i),
    .set_i     (edge_set),
    .rise_en_o (rise_en),
    .fall_en_o (fall_en),
    .flag_o    (flag_q),
    .rdata_o   (rdata_o)
  );

  assign summary_o = |flag_q;
  assign irq_o     = summary_o & master_en_i;
  assign wake_o    = irq_o & sleep_i;
endmodule

// File: rtl/pin_change_irq_chk.sv
module pin_change_irq_chk #(
  parameter int unsigned W = 8
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         master_en_i,
  input logic         sleep_i,
  input logic         wr_en_i,
  input logic [1:0]   addr_i,
  input logic [W-1:0] flag_q,
  input logic [W-1:0] edge_set,
  input logic         irq_o,
  input logic         wake_o
);
  // R4
  irq_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> master_en_i);

  // R9
  wake_sleep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |-> (sleep_i && irq_o));

  // R6
  flag_clear_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|($past(flag_q) & ~flag_q)) |-> $past(wr_en_i && addr_i == 2'd2));

  // R2
  flag_set_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(flag_q & ~$past(flag_q))) |-> (|$past(edge_set)));

  // R7
  set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((|$past(edge_set)) |-> ((flag_q & $past(edge_set)) == $past(edge_set))));
endmodule

bind pin_change_irq pin_change_irq_chk #(.W(W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .master_en_i (master_en_i),
  .sleep_i     (sleep_i),
  .wr_en_i     (wr_en_i),
  .addr_i      (addr_i),
  .flag_q      (flag_q),
  .edge_set    (edge_set),
  .irq_o       (irq_o),
  .wake_o      (wake_o)
);

// File: tb/tb_pin_change_irq.sv
module tb_pin_change_irq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] pins = '0;
  logic       me = 1'b0, slp = 1'b0, wr = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       summary, irq, wake;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  pin_change_irq dut (
    .clk_i(clk), .rst_ni(rst_n), .pins_i(pins), .master_en_i(me),
    .sleep_i(slp), .wr_en_i(wr), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .summary_o(summary), .irq_o(irq), .wake_o(wake)
  );

  always #5 clk = ~clk;

  task automatic chk(string req, string what, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  // behavioural reference: pin history delay line plus register images
  logic [7:0] m_rise = '0, m_fall = '0, m_flag = '0;
  logic [7:0] h1 = '0, h2 = '0, h3 = '0;

  always @(posedge clk or negedge rst_n) begin
    logic [7:0] hits, clr;
    if (!rst_n) begin
      m_rise = '0; m_fall = '0; m_flag = '0;
      h1 = pins; h2 = pins; h3 = pins;
    end else begin
      hits = (h2 & ~h3 & m_rise) | (~h2 & h3 & m_fall);
      clr  = (wr && addr == 2'd2) ? ~wdata : 8'h00;
      m_flag = (m_flag & ~clr) | hits;
      if (wr && addr == 2'd0) m_rise = wdata;
      if (wr && addr == 2'd1) m_fall = wdata;
      h3 = h2; h2 = h1; h1 = pins;
    end
  end

  always @(posedge clk) begin
    logic [7:0] e_rd;
    logic       e_sum;
    #2;
    if (rst_n && !done) begin
      case (addr)
        2'd0: e_rd = m_rise;
        2'd1: e_rd = m_fall;
        2'd2: e_rd = m_flag;
        default: e_rd = 8'h00;
      endcase
      e_sum = |m_flag;
      chk("R1", "model rdata", rdata, e_rd);
      chk("R5", "model summary", {7'b0, summary}, {7'b0, e_sum});
      chk("R4", "model irq", {7'b0, irq}, {7'b0, e_sum & me});
      chk("R9", "model wake", {7'b0, wake}, {7'b0, e_sum & me & slp});
    end
  end

  task automatic step(int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wreg(logic [1:0] a, logic [7:0] d);
    wr = 1'b1; addr = a; wdata = d;
    step();
    wr = 1'b0; addr = 2'd2;
  endtask

  task automatic rd(logic [1:0] a, output logic [7:0] v);
    addr = a; #1; v = rdata;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #2000000;
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [7:0] v;
    step(3);
    rst_n = 1'b1;
    step(2);
    // R10 reset state
    rd(2'd0, v); chk("R10", "rise after reset", v, 8'h00);
    rd(2'd1, v); chk("R10", "fall after reset", v, 8'h00);
    rd(2'd2, v); chk("R10", "flag after reset", v, 8'h00);

    // R1 register map
    wreg(2'd0, 8'h0F);
    wreg(2'd1, 8'hF0);
    rd(2'd0, v); chk("R1", "rise readback", v, 8'h0F);
    rd(2'd1, v); chk("R1", "fall readback", v, 8'hF0);
    rd(2'd3, v); chk("R1", "spare select", v, 8'h00);
    addr = 2'd2;

    // R2 / R3 with master off
    pins = 8'h01; step(4);
    rd(2'd2, v); chk("R2", "rise pin0", v, 8'h01);
    chk("R3", "irq off", {7'b0, irq}, 8'h00);
    pins = 8'h81; step(4);
    rd(2'd2, v); chk("R2", "rise pin7 not armed", v, 8'h01);
    pins = 8'h01; step(4);
    rd(2'd2, v); chk("R2", "fall pin7", v, 8'h81);
    pins = 8'h00; step(4);
    rd(2'd2, v); chk("R2", "fall pin0 not armed", v, 8'h81);

    // R4 / R5
    me = 1'b1; step();
    chk("R4", "irq on", {7'b0, irq}, 8'h01);
    chk("R5", "summary", {7'b0, summary}, 8'h01);

    // R6 write-0 clears, write-1 keeps
    wreg(2'd2, 8'h7F);
    rd(2'd2, v); chk("R6", "clear bit7", v, 8'h01);
    wreg(2'd2, 8'hFF);
    rd(2'd2, v); chk("R6", "write ones keeps", v, 8'h01);
    wreg(2'd2, 8'h00);
    rd(2'd2, v); chk("R6", "clear all", v, 8'h00);
    chk("R4", "irq drops", {7'b0, irq}, 8'h00);

    // R2 both directions on pin2
    wreg(2'd0, 8'h04);
    wreg(2'd1, 8'h04);
    pins = 8'h04; step(4);
    rd(2'd2, v); chk("R2", "both: rise", v, 8'h04);
    wreg(2'd2, 8'h00);
    pins = 8'h00; step(4);
    rd(2'd2, v); chk("R2", "both: fall", v, 8'h04);

    // R7 collision: set bit1, then clear all in the cycle pin2 rise is detected
    wreg(2'd0, 8'h06);
    wreg(2'd1, 8'h00);
    wreg(2'd2, 8'h00);
    pins = 8'h02; step(4);
    rd(2'd2, v); chk("R2", "pin1 rise", v, 8'h02);
    pins = 8'h06;              // sampled at edge k
    step(2);                   // after k+1
    wr = 1'b1; addr = 2'd2; wdata = 8'h00;  // lands at edge k+2
    step();
    wr = 1'b0;
    rd(2'd2, v); chk("R7", "set beats clear", v, 8'h04);

    // R8 enable toggles do not create transitions
    wreg(2'd2, 8'h00);
    wreg(2'd0, 8'hFF);
    wreg(2'd1, 8'hFF);
    wreg(2'd0, 8'h00);
    wreg(2'd1, 8'h00);
    wreg(2'd1, 8'hFF);
    step(4);
    rd(2'd2, v); chk("R8", "enable toggle", v, 8'h00);

    // R9 wake
    wreg(2'd1, 8'h00);
    wreg(2'd0, 8'h10);
    slp = 1'b1; step();
    chk("R9", "no wake idle", {7'b0, wake}, 8'h00);
    pins = 8'h16; step(4);
    chk("R9", "wake asserted", {7'b0, wake}, 8'h01);
    me = 1'b0; #1;
    chk("R9", "wake gated by master", {7'b0, wake}, 8'h00);
    me = 1'b1; slp = 1'b0; #1;
    chk("R9", "wake gated by sleep", {7'b0, wake}, 8'h00);

    // R10 mid-run reset, R8 level across reset release
    pins = 8'hFF; step();
    rst_n = 1'b0; step(2);
    rd(2'd0, v); chk("R10", "rise cleared", v, 8'h00);
    rd(2'd2, v); chk("R10", "flag cleared", v, 8'h00);
    rst_n = 1'b1;
    wreg(2'd0, 8'hFF);
    wreg(2'd1, 8'hFF);
    step(5);
    rd(2'd2, v); chk("R8", "reset level no edge", v, 8'h00);

    step(2);
    finish_run();
  end
endmodule